// File: doc/BRIEF.md
# Early/Prompt/Late Correlation Accumulator Bank

This block integrates the correlation results for a set of tracking channels. Each channel takes carrier-wiped I and Q baseband samples of one or two bits, each with its own valid strobe. It multiplies every sample by three replica code bits: early, prompt and late. It keeps six signed running sums per channel: I and Q for each of early, prompt and late. The sums are 16 bits wide by default and saturate at their limits instead of wrapping.

Each channel has its own code-wrap strobe from its code generator, nominally once per millisecond. The channels are not aligned to each other. On a wrap, the six sums are copied into holding registers and the integrators start again. The channel's new-data bit is also set. Software reads the holding registers through a flat read port. Reading the channel's prompt I result clears its new-data bit. Results that are not read before the next wrap are overwritten.

Top module: `epl_corr_bank`

## Requirements
- R1: The read address is {channel, field}, with the field in the low 3 bits. The field codes are 0 I-early, 1 Q-early, 2 I-prompt, 3 Q-prompt, 4 I-late and 5 Q-late. Fields 6 and 7 read as zero. The read data is combinational, in two's complement.
- R2: A sample is sign-magnitude. Its top bit set means negative, and the remaining low bits m give a magnitude of 2m+1. A 2-bit sample therefore decodes 00 to +1, 01 to +3, 10 to -1 and 11 to -3.
- R3: A replica code bit of 1 negates the sample and a code bit of 0 passes it unchanged. The early code feeds the two early sums, the prompt code the prompt sums and the late code the late sums.
- R4: A sample whose valid bit is low does not change any sum.
- R5: On a channel's wrap cycle, the holding registers take the sums of all samples before that cycle. The sample presented in the wrap cycle, if valid, becomes the first term of the new integration.
- R6: A wrap on one channel changes neither the holding registers nor the new-data bit of any other channel.
- R7: A wrap sets the channel's new-data bit from the next cycle on.
- R8: A read with the read enable high and field 2 clears that channel's new-data bit in the next cycle. Reads of other fields leave it unchanged. A wrap in the same cycle as the clearing read leaves the bit set.
- R9: A wrap replaces the held results whether or not they have been read.
- R10: A sum that would exceed +32767 stays at +32767, and one that would fall below -32768 stays at -32768.
- R11: After reset, all sums, all holding registers and all new-data bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | NCH | Per-channel sample valid |
| smp_i | input | NCH*SW | Per-channel in-phase sample, channel c at bits c*SW |
| smp_q | input | NCH*SW | Per-channel quadrature sample |
| code_e | input | NCH | Early replica code bit per channel |
| code_p | input | NCH | Prompt replica code bit per channel |
| code_l | input | NCH | Late replica code bit per channel |
| code_wrap | input | NCH | Code-period boundary strobe per channel |
| rd_en | input | 1 | Read strobe; a strobed prompt-I read clears new-data |
| rd_addr | input | CHB+3 | Read address {channel, field} |
| rd_data | output | AW | Held result selected by rd_addr |
| new_data | output | NCH | Per-channel fresh-result flags |

## Verification
The two actions that can coincide are a channel's wrap and the software read of that channel's prompt I result. One sets the new-data bit and the other clears it. The bench forces both in the same cycle on purpose and expects the bit to stay set. Random traffic also produces such collisions now and then, alongside wraps that fall on valid samples. Each outcome is compared with a cycle model kept in the bench.

// File: rtl/epl_corr_bank.sv
module epl_corr_bank #(
  parameter int NCH = 4,
  parameter int SW  = 2,
  parameter int AW  = 16,
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = CHB + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    smp_vld,
  input  logic [NCH*SW-1:0] smp_i,
  input  logic [NCH*SW-1:0] smp_q,
  input  logic [NCH-1:0]    code_e,
  input  logic [NCH-1:0]    code_p,
  input  logic [NCH-1:0]    code_l,
  input  logic [NCH-1:0]    code_wrap,
  input  logic              rd_en,
  input  logic [RAW-1:0]    rd_addr,
  output logic [AW-1:0]     rd_data,
  output logic [NCH-1:0]    new_data
);

  localparam logic signed [AW:0] MAXV = {2'b00, {(AW-1){1'b1}}};
  localparam logic signed [AW:0] MINV = {2'b11, {(AW-1){1'b0}}};

  logic [NCH-1:0][5:0][AW-1:0] acc_q;
  logic [NCH-1:0][5:0][AW-1:0] hold_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic clr_rd;
    assign clr_rd = rd_en && rd_addr[2:0] == 3'd2 && rd_addr[RAW-1:3] == CHB'(c);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            new_data[c] <= 1'b0;
      else if (code_wrap[c]) new_data[c] <= 1'b1;
      else if (clr_rd)       new_data[c] <= 1'b0;

    for (genvar k = 0; k < 6; k++) begin : g_arm
      logic [SW-1:0]          s;
      logic                   cb;
      logic [SW:0]            mag;
      logic signed [AW:0]     term, base, sum;
      logic [AW-1:0]          nxt;

      assign s    = (k % 2 == 1) ? smp_q[c*SW +: SW] : smp_i[c*SW +: SW];
      assign cb   = (k / 2 == 0) ? code_e[c] : (k / 2 == 1) ? code_p[c] : code_l[c];
      assign mag  = (({1'b0, s} << 1) | (SW+1)'(1)) & {1'b0, {SW{1'b1}}};
      assign term = (s[SW-1] ^ cb) ? -$signed((AW+1)'(mag)) : $signed((AW+1)'(mag));
      assign base = code_wrap[c] ? '0 : $signed({acc_q[c][k][AW-1], acc_q[c][k]});
      assign sum  = base + (smp_vld[c] ? term : '0);
      assign nxt  = (sum > MAXV) ? MAXV[AW-1:0] : (sum < MINV) ? MINV[AW-1:0] : sum[AW-1:0];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          acc_q[c][k]  <= '0;
          hold_q[c][k] <= '0;
        end else begin
          acc_q[c][k] <= nxt;
          if (code_wrap[c]) hold_q[c][k] <= acc_q[c][k];
        end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 6; k++)
        if (rd_addr[RAW-1:3] == CHB'(c) && rd_addr[2:0] == 3'(k))
          rd_data = hold_q[c][k];
  end

endmodule

// File: rtl/epl_corr_bank_chk.sv
module epl_corr_bank_chk #(
  parameter int NCH = 4,
  parameter int SW  = 2,
  parameter int AW  = 16,
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = CHB + 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NCH-1:0]              code_wrap,
  input logic                        rd_en,
  input logic [RAW-1:0]              rd_addr,
  input logic [NCH-1:0]              new_data,
  input logic [NCH-1:0][5:0][AW-1:0] acc_q,
  input logic [NCH-1:0][5:0][AW-1:0] hold_q
);

  localparam logic [AW-1:0] MAXU = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINU = {1'b1, {(AW-1){1'b0}}};

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic rd_ip;
    assign rd_ip = rd_en && rd_addr == {CHB'(c), 3'd2};

    assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      code_wrap[c] |=> new_data[c]);
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ip && !code_wrap[c]) |=> !new_data[c]);
    assert_flag_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_ip && !code_wrap[c]) |=> $stable(new_data[c]));
    assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !code_wrap[c] |=> $stable(hold_q[c]));
    assert_dump_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      code_wrap[c] |=> hold_q[c] == $past(acc_q[c]));

    for (genvar k = 0; k < 6; k++) begin : g_k
      assert_no_wrap_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q[c][k] == MAXU && !code_wrap[c]) |=> acc_q[c][k] != MINU);
      assert_no_wrap_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q[c][k] == MINU && !code_wrap[c]) |=> acc_q[c][k] != MAXU);
    end
  end

endmodule

bind epl_corr_bank epl_corr_bank_chk #(.NCH(NCH), .SW(SW), .AW(AW)) chk_i (.*);

// File: tb/epl_corr_bank_tb_top.sv
module epl_corr_bank_tb_top;
  localparam int NCH = 4, SW = 2, AW = 16;
  localparam int MAXS = 32767, MINS = -32768;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] vld = '0, ce = '0, cp = '0, cl = '0, wr = '0;
  logic [NCH*SW-1:0] si = '0, sq = '0;
  logic rd_en = 0;
  logic [4:0] rd_addr = '0;
  logic [AW-1:0] rd_data;
  logic [NCH-1:0] new_data;

  int nchk = 0, nfail = 0;
  int macc[NCH][6], mhold[NCH][6];
  bit mnd[NCH];

  always #4 clk = ~clk;

  epl_corr_bank dut_i (.clk, .rst_n, .smp_vld(vld), .smp_i(si), .smp_q(sq),
    .code_e(ce), .code_p(cp), .code_l(cl), .code_wrap(wr),
    .rd_en, .rd_addr, .rd_data, .new_data);

  function automatic int term(logic [1:0] s, logic cb);
    int v = 2 * int'(s[0]) + 1;
    return (s[1] ^ cb) ? -v : v;
  endfunction

  function automatic int sat(int v);
    return v > MAXS ? MAXS : (v < MINS ? MINS : v);
  endfunction

  function automatic int mread(logic [4:0] a);
    if (a[2:0] > 3'd5) return 0;
    return mhold[a[4:3]][a[2:0]];
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    for (int c = 0; c < NCH; c++) begin
      if (rd_en && rd_addr[2:0] == 3'd2 && rd_addr[4:3] == c) mnd[c] = 0;
      for (int k = 0; k < 6; k++) begin
        logic [1:0] s = (k % 2) ? sq[c*SW +: SW] : si[c*SW +: SW];
        logic cb = (k / 2 == 0) ? ce[c] : (k / 2 == 1) ? cp[c] : cl[c];
        int t = vld[c] ? term(s, cb) : 0;
        if (wr[c]) begin
          mhold[c][k] = macc[c][k];
          macc[c][k] = t;
        end else macc[c][k] = sat(macc[c][k] + t);
      end
      if (wr[c]) mnd[c] = 1;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    vld = '0; ce = '0; cp = '0; cl = '0; wr = '0; si = '0; sq = '0; rd_en = 0;
  endtask

  task automatic rd(int c, int k, string tag, int exp);
    rd_addr = 5'(c * 8 + k);
    #1;
    chk(tag, int'($signed(rd_data)), exp);
  endtask

  task automatic chk_nd(string tag);
    logic [NCH-1:0] e;
    for (int c = 0; c < NCH; c++) e[c] = mnd[c];
    chk(tag, int'(new_data), int'(e));
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    for (int c = 0; c < NCH; c++) begin
      mnd[c] = 0;
      for (int k = 0; k < 6; k++) begin macc[c][k] = 0; mhold[c][k] = 0; end
    end
    repeat (3) @(negedge clk);
    chk("R11 new_data after reset", int'(new_data), 0);
    for (int c = 0; c < NCH; c++) for (int k = 0; k < 6; k++) rd(c, k, "R11 hold after reset", 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3: one sample then wrap on channel 0
    idle(); vld[0] = 1; si[1:0] = 2'b11; sq[1:0] = 2'b01; cp[0] = 1;
    step();
    idle(); wr[0] = 1;
    step();
    idle();
    chk("R7 new_data after wrap", int'(new_data), 1);
    rd(0, 0, "R2 I-early -3", -3); rd(0, 1, "R2 Q-early +3", 3);
    rd(0, 2, "R3 I-prompt negated", 3); rd(0, 3, "R3 Q-prompt negated", -3);
    rd(0, 4, "R3 I-late", -3); rd(0, 5, "R3 Q-late", 3);
    rd(0, 6, "R1 field 6 zero", 0); rd(0, 7, "R1 field 7 zero", 0);

    // R4 R5 R9: small magnitudes, invalid sample, wrap with valid sample
    vld[0] = 1; si[1:0] = 2'b00; sq[1:0] = 2'b10; step();
    vld[0] = 0; si[1:0] = 2'b11; sq[1:0] = 2'b11; step();
    vld[0] = 1; si[1:0] = 2'b01; sq[1:0] = 2'b00; wr[0] = 1; step();
    idle();
    rd(0, 0, "R4 R9 I-early +1", 1); rd(0, 1, "R4 R9 Q-early -1", -1);
    wr[0] = 1; step(); idle();
    rd(0, 0, "R5 wrap-cycle sample carried", 3); rd(0, 1, "R5 wrap-cycle Q carried", 1);

    // R8 clearing
    rd_en = 1; rd_addr = 5'd0; step(); rd_en = 0;
    chk("R8 non-prompt read keeps flag", int'(new_data[0]), 1);
    rd_en = 1; rd_addr = 5'd10; step(); rd_en = 0;
    chk("R8 other channel read keeps flag", int'(new_data[0]), 1);
    rd_en = 1; rd_addr = 5'd2; step(); rd_en = 0;
    chk("R8 prompt read clears flag", int'(new_data[0]), 0);
    wr[0] = 1; step(); idle();
    rd_en = 1; rd_addr = 5'd2; wr[0] = 1; step(); idle();
    chk("R8 wrap wins over clear", int'(new_data[0]), 1);
    chk_nd("R8 model flags");

    // R6 independent channel
    wr[2] = 1; step(); idle();
    chk_nd("R6 only channel 2 flag added");
    rd(0, 0, "R6 channel 0 hold unchanged", mhold[0][0]);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      vld = NCH'($urandom); si = NCH*SW'($urandom); sq = NCH*SW'($urandom);
      ce = NCH'($urandom); cp = NCH'($urandom); cl = NCH'($urandom);
      for (int c = 0; c < NCH; c++) wr[c] = ($urandom % 48) == 0;
      rd_en = ($urandom % 4) == 0;
      rd_addr = 5'($urandom);
      if ($urandom % 3 == 0) rd_addr[2:0] = 3'd2;
      #1;
      chk("R1 R5 R9 random read", int'($signed(rd_data)), mread(rd_addr));
      chk_nd("R7 R8 random flags");
      step();
    end
    idle();

    // R10 saturation on all channels
    wr = '1; step(); idle();
    vld = '1; si = {NCH{2'b01}}; sq = {NCH{2'b11}};
    repeat (11500) step();
    wr = '1; step(); idle();
    for (int c = 0; c < NCH; c++) begin
      rd(c, 0, "R10 positive saturation", MAXS);
      rd(c, 1, "R10 negative saturation", MINS);
      rd(c, 4, "R10 late positive saturation", mhold[c][4]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule